// File: doc/BRIEF.md
# USB Control Endpoint IN Buffer

This block holds the payload a USB device returns during the data stage of a control read. Firmware loads bytes one at a time through a byte-wide write port, then raises an end-of-data strobe to close the packet, and finally opens the gate by setting a NAK-release bit. The protocol engine reports token and handshake events. The block answers each IN token with a NAK pulse or with a packet, which it streams out over a valid/ready byte channel.

A packet may be short, or zero-length when end-of-data is raised on an empty buffer. When the host acknowledges the packet, the buffer empties and the NAK-release bit drops by itself. A missed handshake leaves the bytes in place for a replay. A SETUP token, or an early move to the status stage, discards whatever was loaded.

Top module: `ep0in_buf`

## Requirements
- R1: After reset the buffer is empty, `nak_rel_o`, `data_avail_o`, `ovf_o`, `nak_o` and `tx_valid_o` are 0.
- R2: `cpu_rdata_o` reads 0x00 after any read strobe, whether the buffer is empty or holds data.
- R3: While `nak_rel_o` is 0, an IN token in the idle state gives `nak_o` high for the following cycle and no byte is streamed.
- R4: With `nak_rel_o` 1 and end-of-data set, an IN token streams the loaded bytes in write order, starting the cycle after the token, with `tx_last_o` on the final byte and `tx_zlp_o` 0.
- R5: End-of-data on an empty buffer yields a single beat with `tx_zlp_o` 1, `tx_last_o` 1 and `tx_data_o` 0x00.
- R6: `data_avail_o` is 1 once end-of-data has been set, or once the buffer holds DEPTH bytes.
- R7: An ACK after the last beat clears `nak_rel_o`, `data_avail_o` and the buffer contents.
- R8: A handshake timeout after a packet keeps the contents and `nak_rel_o`, and the next IN token resends the same bytes.
- R9: A write to a full buffer is dropped and sets `ovf_o`, which stays 1 through ACKs until a flush.
- R10: CPU writes made while a packet is being sent or awaiting its handshake are ignored.
- R11: A SETUP token empties the buffer and clears end-of-data and `ovf_o`, leaving `nak_rel_o` unchanged.
- R12: A status-stage event before the ACK empties the buffer and clears end-of-data, even while `nak_rel_o` is 1.
- R13: With `nak_rel_o` 1 but `data_avail_o` 0, an IN token is answered with NAK.
- R14: While `tx_ready_i` is 0, `tx_valid_o` stays 1 and `tx_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_wr_i | input | 1 | Byte write strobe |
| cpu_wdata_i | input | 8 | Byte to load |
| cpu_rd_i | input | 1 | Data port read strobe |
| cpu_rdata_o | output | 8 | Data port read value, always 0x00 |
| nak_rel_set_i | input | 1 | Sets the NAK-release bit |
| eod_set_i | input | 1 | Marks end of packet data |
| nak_rel_o | output | 1 | NAK-release bit |
| data_avail_o | output | 1 | Packet ready to send |
| ovf_o | output | 1 | Sticky overflow flag |
| tok_in_i | input | 1 | IN token received |
| tok_setup_i | input | 1 | SETUP token received |
| status_stage_i | input | 1 | Control transfer entered status stage |
| ack_i | input | 1 | Host ACK received |
| hs_timeout_i | input | 1 | Handshake missing or corrupted |
| nak_o | output | 1 | Answer the IN token with NAK |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream byte accepted |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final beat of packet |
| tx_zlp_o | output | 1 | Beat is a zero-length packet marker |

## Verification
A stale write count appears as a wrong length or a wrong `tx_last_o` position in the next streamed packet. A missed flush shows up as an ordinary packet where a zero-length one is due. Both are visible within the packet that follows the faulty event. A read pointer that is not rewound corrupts the replay after a timeout, starting from its first byte. A gate that is stuck open or stuck closed shows at `nak_o` one cycle after the IN token.

// File: rtl/ep0in_pkg.sv
package ep0in_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } ep0in_st_e;
endpackage

// File: rtl/ep0in_store.sv
module ep0in_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          clr_i,
  input  logic          rd_rewind_i,
  input  logic          rd_adv_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_last_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] rd_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk_i) begin
      if (wr_en_i && !full_o && (cnt_q == CW'(g))) mem_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (wr_en_i && !full_o) cnt_q <= cnt_q + CW'(1);
  end

  // replay pointer: rewound at each packet start, write count untouched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rd_q <= '0;
    else if (clr_i || rd_rewind_i)   rd_q <= '0;
    else if (rd_adv_i && !rd_last_o) rd_q <= rd_q + CW'(1);
  end

  assign rd_data_o = mem_q[rd_q[AW-1:0]];
  assign rd_last_o = ((rd_q + CW'(1)) == cnt_q);
endmodule

// File: rtl/ep0in_seq.sv
module ep0in_seq
  import ep0in_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cpu_wr_i,
  input  logic      nak_rel_set_i,
  input  logic      eod_set_i,
  input  logic      tok_in_i,
  input  logic      tok_setup_i,
  input  logic      status_stage_i,
  input  logic      ack_i,
  input  logic      hs_timeout_i,
  input  logic      tx_ready_i,
  input  logic      empty_i,
  input  logic      full_i,
  input  logic      rd_last_i,
  output ep0in_st_e st_o,
  output logic      wr_en_o,
  output logic      clr_o,
  output logic      rd_rewind_o,
  output logic      rd_adv_o,
  output logic      nak_rel_o,
  output logic      data_avail_o,
  output logic      ovf_o,
  output logic      nak_o,
  output logic      tx_valid_o,
  output logic      tx_last_o,
  output logic      tx_zlp_o
);
  ep0in_st_e st_q, st_d;
  logic eod_q, nak_rel_q, ovf_q, nak_q;
  logic flush, start, fire, acked, wr_ok;

  assign flush        = tok_setup_i | status_stage_i;
  assign data_avail_o = eod_q | full_i;
  assign start        = (st_q == ST_IDLE) && tok_in_i && nak_rel_q && data_avail_o && !flush;
  assign tx_valid_o   = (st_q == ST_SEND);
  assign tx_zlp_o     = tx_valid_o && empty_i;
  assign tx_last_o    = tx_valid_o && (empty_i || rd_last_i);
  assign fire         = tx_valid_o && tx_ready_i;
  assign acked        = (st_q == ST_WAIT) && ack_i && !flush;
  assign wr_ok        = cpu_wr_i && (st_q == ST_IDLE) && !flush;

  assign wr_en_o     = wr_ok;
  assign clr_o       = flush | acked;
  assign rd_rewind_o = start;
  assign rd_adv_o    = fire;

  always_comb begin
    st_d = st_q;
    if (flush) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE: if (start) st_d = ST_SEND;
        ST_SEND: if (fire && tx_last_o) st_d = ST_WAIT;
        ST_WAIT: if (ack_i || hs_timeout_i) st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      eod_q     <= 1'b0;
      nak_rel_q <= 1'b0;
      ovf_q     <= 1'b0;
      nak_q     <= 1'b0;
    end else begin
      st_q  <= st_d;
      nak_q <= tok_in_i && (st_q == ST_IDLE) && !start && !flush;
      if (clr_o)                               eod_q <= 1'b0;
      else if (eod_set_i && st_q == ST_IDLE)   eod_q <= 1'b1;
      if (acked)                               nak_rel_q <= 1'b0;
      else if (nak_rel_set_i)                  nak_rel_q <= 1'b1;
      if (tok_setup_i)                         ovf_q <= 1'b0;
      else if (wr_ok && full_i)                ovf_q <= 1'b1;
    end
  end

  assign st_o      = st_q;
  assign nak_rel_o = nak_rel_q;
  assign ovf_o     = ovf_q;
  assign nak_o     = nak_q;
endmodule

// File: rtl/ep0in_buf.sv
module ep0in_buf #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_wr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          cpu_rd_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          nak_rel_set_i,
  input  logic          eod_set_i,
  output logic          nak_rel_o,
  output logic          data_avail_o,
  output logic          ovf_o,
  input  logic          tok_in_i,
  input  logic          tok_setup_i,
  input  logic          status_stage_i,
  input  logic          ack_i,
  input  logic          hs_timeout_i,
  output logic          nak_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_last_o,
  output logic          tx_zlp_o
);
  import ep0in_pkg::*;

  ep0in_st_e     st_w;
  logic          wr_en, clr, rd_rewind, rd_adv, rd_last, empty, full;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] rdata_q;

  ep0in_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_data_i(cpu_wdata_i), .clr_i(clr),
    .rd_rewind_i(rd_rewind), .rd_adv_i(rd_adv),
    .rd_data_o(rd_data), .rd_last_o(rd_last),
    .empty_o(empty), .full_o(full)
  );

  ep0in_seq i_seq (
    .clk_i, .rst_ni,
    .cpu_wr_i, .nak_rel_set_i, .eod_set_i,
    .tok_in_i, .tok_setup_i, .status_stage_i, .ack_i, .hs_timeout_i, .tx_ready_i,
    .empty_i(empty), .full_i(full), .rd_last_i(rd_last),
    .st_o(st_w), .wr_en_o(wr_en), .clr_o(clr),
    .rd_rewind_o(rd_rewind), .rd_adv_o(rd_adv),
    .nak_rel_o, .data_avail_o, .ovf_o, .nak_o,
    .tx_valid_o, .tx_last_o, .tx_zlp_o
  );

  // data port is write-only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (cpu_rd_i) rdata_q <= '0;
  end
  assign cpu_rdata_o = rdata_q;

  assign tx_data_o = tx_zlp_o ? '0 : rd_data;
endmodule

// File: rtl/ep0in_buf_chk.sv
module ep0in_buf_chk
  import ep0in_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tok_in_i,
  input logic          tok_setup_i,
  input logic          status_stage_i,
  input logic          ack_i,
  input logic          nak_rel_set_i,
  input logic          tx_ready_i,
  input logic          nak_o,
  input logic          nak_rel_o,
  input logic          data_avail_o,
  input logic          ovf_o,
  input logic          tx_valid_o,
  input logic [DW-1:0] tx_data_o,
  input logic          tx_last_o,
  input logic          tx_zlp_o,
  input ep0in_st_e     st
);
  logic fl;
  assign fl = tok_setup_i | status_stage_i;

  a_r3_nak_when_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_in_i && !nak_rel_o && st == ST_IDLE && !fl) |=> (nak_o && !tx_valid_o));

  a_r13_nak_when_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_in_i && !data_avail_o && st == ST_IDLE && !fl) |=> nak_o);

  a_r3_nak_excludes_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nak_o && tx_valid_o));

  a_r5_zlp_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_zlp_o) |-> (tx_last_o && tx_data_o == '0));

  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_WAIT && ack_i && !fl && !nak_rel_set_i) |=> (!nak_rel_o && !data_avail_o));

  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !tok_setup_i) |=> ovf_o);

  a_r14_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !fl) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

bind ep0in_buf ep0in_buf_chk #(.DW(DW)) i_chk (
  .clk_i, .rst_ni, .tok_in_i, .tok_setup_i, .status_stage_i, .ack_i,
  .nak_rel_set_i, .tx_ready_i, .nak_o, .nak_rel_o, .data_avail_o, .ovf_o,
  .tx_valid_o, .tx_data_o, .tx_last_o, .tx_zlp_o, .st(st_w)
);

// File: tb/test_ep0in_buf.sv
module test_ep0in_buf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 0, cpu_rd = 0, nrs = 0, eod = 0;
  logic tin = 0, tsu = 0, sts = 0, ack = 0, tmo = 0, rdy = 1;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, txd;
  logic nrel, avail, ovf, nak, txv, txl, txz;

  int checks = 0, errors = 0;
  logic [7:0] got [65];
  int got_n;
  logic got_zlp, got_nak;

  localparam int NPKT = 6;
  localparam int LENS  [NPKT] = '{1, 3, 8, 17, 63, 64};
  localparam int SEEDS [NPKT] = '{8'h10, 8'hA0, 8'h33, 8'h01, 8'h7E, 8'hC4};

  always #2.5 clk = ~clk;

  ep0in_buf i_ep0in_buf (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_wr_i(cpu_wr), .cpu_wdata_i(wdata), .cpu_rd_i(cpu_rd), .cpu_rdata_o(rdata),
    .nak_rel_set_i(nrs), .eod_set_i(eod), .nak_rel_o(nrel), .data_avail_o(avail), .ovf_o(ovf),
    .tok_in_i(tin), .tok_setup_i(tsu), .status_stage_i(sts), .ack_i(ack), .hs_timeout_i(tmo),
    .nak_o(nak), .tx_valid_o(txv), .tx_ready_i(rdy), .tx_data_o(txd), .tx_last_o(txl), .tx_zlp_o(txz)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); cpu_wr = 1; wdata = b;
    @(negedge clk); cpu_wr = 0;
  endtask

  // 0 nak_rel set, 1 eod, 2 in, 3 setup, 4 status, 5 ack, 6 timeout, 7 rd
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: nrs = 1; 1: eod = 1; 2: tin = 1; 3: tsu = 1;
      4: sts = 1; 5: ack = 1; 6: tmo = 1; default: cpu_rd = 1;
    endcase
    @(negedge clk);
    {nrs, eod, tin, tsu, sts, ack, tmo, cpu_rd} = '0;
  endtask

  task automatic collect();
    got_n = 0; got_zlp = 0;
    rdy = 1;
    for (int k = 0; k < 200; k++) begin
      if (txv) begin
        if (got_n < 65) got[got_n] = txd;
        got_zlp = txz;
        got_n++;
        if (txl) begin @(negedge clk); break; end
      end
      @(negedge clk);
    end
  endtask

  task automatic do_in();
    pulse(2);
    got_nak = nak;
    got_n = 0; got_zlp = 0;
    if (!got_nak) collect();
  endtask

  task automatic load(input int len, input int seed);
    for (int i = 0; i < len; i++) wr_byte(8'(seed + i));
  endtask

  task automatic expect_pkt(input string req, input int len, input int seed);
    chk(!got_nak, req, got_nak, 0);
    chk(got_n == len, req, got_n, len);
    for (int i = 0; i < len && i < 65; i++)
      chk(got[i] == 8'(seed + i), req, got[i], 8'(seed + i));
    chk(!got_zlp, req, got_zlp, 0);
  endtask

  task automatic expect_zlp(input string req);
    chk(!got_nak && got_n == 1 && got_zlp && got[0] == 8'h00, req, got_n, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!nrel && !avail && !ovf && !nak && !txv, "R1", {nrel, avail, ovf, nak, txv}, 0);
    // R2 read on empty
    pulse(7);
    chk(rdata == 8'h00, "R2", rdata, 0);
    // R3 gate closed
    load(2, 8'h55); pulse(1);
    do_in();
    chk(got_nak, "R3", got_nak, 1);
    chk(!txv, "R3", txv, 0);
    pulse(7);
    chk(rdata == 8'h00, "R2", rdata, 0);
    pulse(3);
    // R13 gate open, nothing ready
    pulse(0);
    do_in();
    chk(got_nak, "R13", got_nak, 1);

    // table: R4 order, R6 avail, R7 ack clears
    for (int p = 0; p < NPKT; p++) begin
      load(LENS[p], SEEDS[p]);
      if (LENS[p] < 64) pulse(1);
      @(negedge clk);
      chk(avail, "R6", avail, 1);
      pulse(0);
      do_in();
      expect_pkt("R4", LENS[p], SEEDS[p]);
      pulse(5);
      chk(!nrel && !avail, "R7", {nrel, avail}, 0);
    end

    // R5 null packet; R7 buffer empty after ack
    pulse(1); pulse(0);
    do_in();
    expect_zlp("R5");
    pulse(5);

    // R8 replay after timeout
    load(4, 8'h90); pulse(1); pulse(0);
    do_in(); expect_pkt("R8", 4, 8'h90);
    pulse(6);
    chk(nrel && avail, "R8", {nrel, avail}, 3);
    do_in(); expect_pkt("R8", 4, 8'h90);
    pulse(5);

    // R10 writes during send ignored, R14 hold under backpressure
    load(2, 8'h20); pulse(1); pulse(0);
    rdy = 0;
    pulse(2);
    begin
      logic [7:0] d0;
      d0 = txd;
      wr_byte(8'hEE);
      chk(txv && txd == d0, "R14", txd, d0);
      chk(d0 == 8'h20, "R14", d0, 8'h20);
    end
    collect();
    chk(got_n == 2, "R10", got_n, 2);
    wr_byte(8'hEF);
    pulse(6);
    do_in();
    expect_pkt("R10", 2, 8'h20);
    pulse(5);

    // R9 overflow
    load(64, 8'h00);
    chk(!ovf, "R9", ovf, 0);
    wr_byte(8'hFF);
    repeat (3) @(negedge clk);
    chk(ovf, "R9", ovf, 1);
    pulse(0);
    do_in();
    expect_pkt("R9", 64, 8'h00);
    pulse(5);
    chk(ovf, "R9", ovf, 1);

    // R11 SETUP flush
    load(3, 8'h40); pulse(1);
    pulse(3);
    chk(!avail && !ovf, "R11", {avail, ovf}, 0);
    pulse(1); pulse(0);
    do_in(); expect_zlp("R11");
    pulse(5);

    // R12 status stage before ACK
    load(5, 8'h60); pulse(1); pulse(0);
    do_in(); expect_pkt("R12", 5, 8'h60);
    pulse(4);
    chk(!avail && nrel, "R12", {avail, nrel}, 1);
    pulse(1);
    do_in(); expect_zlp("R12");
    pulse(5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule